// File: doc/BRIEF.md
# Double-Buffered Terminal Broadcast Controller

This block turns a host's stream of 12-bit words into a frame-periodic serial broadcast for a large population of terminals. Every three host words make one record: a terminal address plus 19 bits of payload. The block protects the payload with an odd parity bit and stores the 20-bit result in a frame memory, at the location named by the address. Two such memories take turns. During one frame the host fills one of them. Meanwhile the other is sent out one bit at a time to a line transmitter, with each bit paced by an external bit-enable strobe.

The readout is destructive: every bit is zeroed as it is fetched. A bank is therefore empty once it has been sent. Any terminal the host skipped during a frame receives an all-zero word, which terminals take as "no operation", so the host only needs to send records to terminals that have news. A frame tick input swaps the roles of the two banks and restarts the readout. If the readout was still busy at the tick, a sticky overrun flag is set. Host words that arrive out of order are dropped and counted. A record may also be marked as the last one of its frame, which closes the fill bank until the next tick.

Top module: `tbc_broadcast_ctrl`

## Requirements
- R1: Three accepted host words w1, w2, w3, where w1 has bit 11 set, form the 30-bit record {w1[9:0], w2[9:0], w3[9:0]}. The terminal address is the low ADDR_W bits of record bits 29:20. Record bits 19:1 are the payload, stored as bits 19:1 of the word at that address in the fill bank. Bits 10 and 11 of w2, and bit 11 of w3, carry no meaning. Record bit 0 is ignored.
- R2: Bit 0 of every stored word is written so that the 20-bit word holds an odd number of ones.
- R3: After reset, bank 0 is the fill bank and bank 1 is the drain bank. Each frame tick swaps the two, so a record written during one frame is transmitted during the next frame.
- R4: The drain bank is sent in passes from bit 19 down to bit 0. Each pass covers locations 0 to READ_LOCS-1 in ascending order, fetched in groups of four. Each transmitted bit appears on tx_bit with tx_strobe high for one cycle, in the cycle after a cycle in which bit_en was high. No strobe follows a fetch cycle.
- R5: Every fetched bit is cleared in the drain bank. A location that received no record during a frame is sent as 20 zero bits, and a bank that has been sent once sends only zeros the next time.
- R6: When no triple is in progress, a host word with bit 11 clear is discarded: nothing is stored, and err_count rises by one, holding at its maximum value.
- R7: A record whose w3 has bit 10 set is stored, and then fill_closed goes high. Records completed while fill_closed is high are not stored. A frame tick clears fill_closed.
- R8: A frame tick restarts the readout, so readout_idle is low in the cycle after a tick. readout_idle goes high once all 20 x READ_LOCS bits have been sent. A tick while readout_idle is low sets overrun, which then stays high until reset.
- R9: After reset, err_count and overrun are 0, fill_closed is low, and both banks hold all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | host_word is valid this cycle |
| host_word | input | 12 | Host word; bit 11 marks the start of a triple, bit 10 of the third word marks the last record |
| frame_tick | input | 1 | One-cycle frame boundary pulse; swaps the banks |
| bit_en | input | 1 | Serial pacing strobe |
| tx_bit | output | 1 | Serial data bit |
| tx_strobe | output | 1 | tx_bit carries a new bit this cycle |
| readout_idle | output | 1 | The drain bank has been fully sent |
| fill_closed | output | 1 | The last record of the frame has been stored |
| overrun | output | 1 | Sticky: a tick came before the readout finished |
| err_count | output | ERR_W | Saturating count of discarded out-of-sequence words |

## Verification
The bench reassembles each frame's serial stream, using the pass-major, ascending-location bit order, back into per-location words. A design that fetched the group in the wrong order, counted the bit index the wrong way, or stopped a pass early would scramble the words and mismatch at written locations. A second readout of the same bank with no writes in between must give only zeros; a design that skipped the clear would repeat stale data there. Records sent after a last-marked record must not appear, and out-of-sequence words must raise the counter without being stored. Finally, a tick that cuts a readout short must set overrun and keep it set, while full frames must never set it.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int HOST_W  = 12;
  localparam int FIELD_W = 10;
  localparam int REC_W   = 3 * FIELD_W;
  localparam int WORD_W  = 20;

  // payload is record bits 19:1; bit 0 of the stored word is odd parity
  function automatic logic [WORD_W-1:0] build_entry(input logic [REC_W-1:0] rec);
    logic [WORD_W-2:0] pay;
    pay = rec[WORD_W-1:1];
    return {pay, ~(^pay)};
  endfunction
endpackage

// File: rtl/tbc_assembler.sv
module tbc_assembler #(
  parameter int ADDR_W = 10,
  parameter int ERR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_valid,
  input  logic [tbc_pkg::HOST_W-1:0] host_word,
  input  logic                      frame_tick,
  output logic                      commit_ev,
  output logic [ADDR_W-1:0]         commit_addr,
  output logic [tbc_pkg::WORD_W-1:0] commit_word,
  output logic                      discard_ev,
  output logic                      fill_closed,
  output logic [ERR_W-1:0]          err_count
);
  localparam int FW = tbc_pkg::FIELD_W;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [1:0]    phase;
  logic [FW-1:0] w1_q, w2_q;
  logic          third_ev;

  assign discard_ev = host_valid && (phase == 2'd0) && !host_word[tbc_pkg::HOST_W-1];
  assign third_ev   = host_valid && (phase == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= 2'd0;
      w1_q        <= '0;
      w2_q        <= '0;
      commit_ev   <= 1'b0;
      commit_addr <= '0;
      commit_word <= '0;
      fill_closed <= 1'b0;
      err_count   <= '0;
    end else begin
      commit_ev <= 1'b0;
      if (host_valid) begin
        case (phase)
          2'd0: begin
            if (host_word[tbc_pkg::HOST_W-1]) begin
              w1_q  <= host_word[FW-1:0];
              phase <= 2'd1;
            end else if (err_count != ERR_MAX) begin
              err_count <= err_count + 1'b1;
            end
          end
          2'd1: begin
            w2_q  <= host_word[FW-1:0];
            phase <= 2'd2;
          end
          default: begin
            phase <= 2'd0;
            if (!fill_closed) begin
              commit_ev   <= 1'b1;
              commit_addr <= w1_q[ADDR_W-1:0];
              commit_word <= tbc_pkg::build_entry({w1_q, w2_q, host_word[FW-1:0]});
            end
          end
        endcase
      end
      if (frame_tick)
        fill_closed <= 1'b0;
      else if (third_ev && !fill_closed && host_word[tbc_pkg::HOST_W-2])
        fill_closed <= 1'b1;
    end
  end
endmodule

// File: rtl/tbc_bank.sv
module tbc_bank #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 20,
  parameter int GROUP  = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [BIT_W-1:0]  rd_bit,
  output logic [GROUP-1:0]  rd_bits
);
  logic [WORD_W-1:0] mem [DEPTH];

  // lowest address of the group lands in the top bit (sent first)
  for (genvar gi = 0; gi < GROUP; gi++) begin : g_rd
    assign rd_bits[GROUP-1-gi] = mem[rd_base + ADDR_W'(gi)][rd_bit];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (clr_en)
        for (int i = 0; i < GROUP; i++) mem[rd_base + ADDR_W'(i)][rd_bit] <= 1'b0;
    end
  end
endmodule

// File: rtl/tbc_reader.sv
module tbc_reader #(
  parameter int ADDR_W    = 10,
  parameter int READ_LOCS = 1008,
  parameter int GROUP     = 4,
  parameter int WORD_W    = 20,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int CNT_W    = $clog2(GROUP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              bit_en,
  input  logic [GROUP-1:0]  grp_bits,
  output logic              load_ev,
  output logic [ADDR_W-1:0] rd_base,
  output logic [BIT_W-1:0]  rd_bit,
  output logic              tx_bit,
  output logic              tx_strobe,
  output logic              idle
);
  localparam logic [ADDR_W-1:0] LAST_BASE = ADDR_W'(READ_LOCS - GROUP);
  localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(WORD_W - 1);

  logic [GROUP-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             fetch_end;

  assign idle    = fetch_end && (cnt == '0);
  assign load_ev = !frame_tick && (cnt == '0) && !fetch_end;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_tick) begin
      rd_base   <= '0;
      rd_bit    <= TOP_BIT;
      sh        <= '0;
      cnt       <= '0;
      fetch_end <= 1'b0;
      tx_bit    <= 1'b0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (load_ev) begin
        sh  <= grp_bits;
        cnt <= CNT_W'(GROUP);
        if (rd_base == LAST_BASE) begin
          rd_base <= '0;
          if (rd_bit == '0) fetch_end <= 1'b1;
          else              rd_bit    <= rd_bit - 1'b1;
        end else begin
          rd_base <= rd_base + ADDR_W'(GROUP);
        end
      end else if ((cnt != '0) && bit_en) begin
        tx_bit    <= sh[GROUP-1];
        sh        <= {sh[GROUP-2:0], 1'b0};
        cnt       <= cnt - 1'b1;
        tx_strobe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbc_broadcast_ctrl.sv
module tbc_broadcast_ctrl #(
  parameter int ADDR_W    = 10,
  parameter int READ_LOCS = 1008,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  input  logic [11:0]      host_word,
  input  logic             frame_tick,
  input  logic             bit_en,
  output logic             tx_bit,
  output logic             tx_strobe,
  output logic             readout_idle,
  output logic             fill_closed,
  output logic             overrun,
  output logic [ERR_W-1:0] err_count
);
  localparam int WORD_W = tbc_pkg::WORD_W;
  localparam int GROUP  = 4;
  localparam int BIT_W  = $clog2(WORD_W);

  logic              commit_ev, discard_ev, load_ev, fill_sel;
  logic [ADDR_W-1:0] commit_addr, rd_base;
  logic [WORD_W-1:0] commit_word;
  logic [BIT_W-1:0]  rd_bit;
  logic [GROUP-1:0]  bank_rd [2];
  logic [GROUP-1:0]  grp_bits;

  tbc_assembler #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) i_asm (
    .clk, .rst_n, .host_valid, .host_word, .frame_tick,
    .commit_ev, .commit_addr, .commit_word, .discard_ev,
    .fill_closed, .err_count
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    tbc_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .GROUP(GROUP)) i_bank (
      .clk, .rst_n,
      .wr_en   (commit_ev && (fill_sel == 1'(g))),
      .wr_addr (commit_addr),
      .wr_data (commit_word),
      .clr_en  (load_ev && (fill_sel != 1'(g))),
      .rd_base, .rd_bit,
      .rd_bits (bank_rd[g])
    );
  end

  assign grp_bits = fill_sel ? bank_rd[0] : bank_rd[1];

  tbc_reader #(.ADDR_W(ADDR_W), .READ_LOCS(READ_LOCS), .GROUP(GROUP), .WORD_W(WORD_W)) i_rd (
    .clk, .rst_n, .frame_tick, .bit_en, .grp_bits, .load_ev,
    .rd_base, .rd_bit, .tx_bit, .tx_strobe, .idle(readout_idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_sel <= 1'b0;
      overrun  <= 1'b0;
    end else if (frame_tick) begin
      fill_sel <= ~fill_sel;
      if (!readout_idle) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_tick,
  input logic             bit_en,
  input logic             tx_strobe,
  input logic             readout_idle,
  input logic             overrun,
  input logic             fill_closed,
  input logic [ERR_W-1:0] err_count,
  input logic             commit_ev,
  input logic             discard_ev,
  input logic             load_ev
);
  assert_strobe_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(bit_en));
  assert_no_strobe_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !tx_strobe);
  assert_err_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    discard_ev |=> (err_count == $past(err_count) + 1'b1) || (&err_count));
  assert_closed_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> !$past(fill_closed));
  assert_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !fill_closed);
  assert_tick_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !readout_idle && !tx_strobe);
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !readout_idle) |=> overrun);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind tbc_broadcast_ctrl tbc_checker #(.ERR_W(ERR_W)) i_tbc_checker (
  .clk, .rst_n, .frame_tick, .bit_en, .tx_strobe, .readout_idle, .overrun,
  .fill_closed, .err_count, .commit_ev, .discard_ev, .load_ev
);

// File: tb/test_tbc_broadcast_ctrl.sv
module test_tbc_broadcast_ctrl;
  localparam int AW    = 6;
  localparam int LOCS  = 60;
  localparam int EW    = 4;
  localparam int NBITS = 20 * LOCS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0;
  logic [11:0] host_word = '0;
  logic frame_tick = 1'b0;
  logic bit_en = 1'b1;
  logic tx_bit, tx_strobe, readout_idle, fill_closed, overrun;
  logic [EW-1:0] err_count;

  tbc_broadcast_ctrl #(.ADDR_W(AW), .READ_LOCS(LOCS), .ERR_W(EW)) i_tbc_broadcast_ctrl (
    .clk, .rst_n, .host_valid, .host_word, .frame_tick, .bit_en,
    .tx_bit, .tx_strobe, .readout_idle, .fill_closed, .overrun, .err_count
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic stream [NBITS];
  int scount = 0;
  logic [19:0] exp_mem [2][LOCS];
  bit fsel = 1'b0;
  bit closed_m = 1'b0;

  always @(negedge clk) begin
    if (tx_strobe) begin
      if (scount < NBITS) stream[scount] = tx_bit;
      scount = scount + 1;
    end
  end

  function automatic int ones20(input logic [19:0] w);
    int n = 0;
    for (int i = 0; i < 20; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic logic [19:0] ref_entry(input logic [18:0] d);
    int n = 0;
    for (int i = 0; i < 19; i++) n += int'(d[i]);
    return {d, (n % 2 == 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_word(input logic [11:0] w);
    @(negedge clk);
    host_valid = 1'b1;
    host_word  = w;
    @(negedge clk);
    host_valid = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic send_triple(input int addr, input logic [18:0] d, input bit last);
    logic junk;
    junk = 1'($urandom);
    send_word({2'b10, 10'(addr)});
    send_word({2'($urandom), d[18:9]});
    send_word({1'($urandom), last, d[8:0], junk});
    if (!closed_m) begin
      exp_mem[fsel][addr] = ref_entry(d);
      if (last) closed_m = 1'b1;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    scount = 0;
    @(negedge clk);
    frame_tick = 1'b0;
    fsel = ~fsel;
    closed_m = 1'b0;
  endtask

  // R4 R5 R1 R2: rebuild each location's word from the pass-major stream
  task automatic verify_frame();
    int drain;
    logic [19:0] got;
    for (int i = 0; i < 6000 && !readout_idle; i++) @(negedge clk);
    @(negedge clk);
    drain = fsel ? 0 : 1;
    chk(readout_idle == 1'b1, "R8 idle after full readout", 32'(readout_idle), 1);
    chk(scount == NBITS, "R4 bits per frame", 32'(scount), NBITS);
    for (int a = 0; a < LOCS; a++) begin
      for (int p = 0; p < 20; p++) got[19-p] = stream[p * LOCS + a];
      if (exp_mem[drain][a] != 0) begin
        chk(got == exp_mem[drain][a], "R1 R3 stored record", 32'(got), 32'(exp_mem[drain][a]));
        chk(ones20(got) % 2 == 1, "R2 odd parity", 32'(ones20(got)), 1);
      end else begin
        chk(got == 20'd0, "R5 no-operation word", 32'(got), 0);
      end
      exp_mem[drain][a] = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a;
    void'($urandom(32'd4242));
    for (int b = 0; b < 2; b++) for (int i = 0; i < LOCS; i++) exp_mem[b][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(err_count == 0, "R9 err_count reset", 32'(err_count), 0);
    chk(overrun == 1'b0, "R9 overrun reset", 32'(overrun), 0);
    chk(fill_closed == 1'b0, "R9 fill_closed reset", 32'(fill_closed), 0);

    // frame 0: fill bank 0, drain bank 1 (zeros from reset)
    send_word(12'h005);
    repeat (2) @(negedge clk);
    chk(err_count == 1, "R6 out-of-sequence counted", 32'(err_count), 1);
    send_triple(0, 19'h7FFFF, 1'b0);
    send_triple(LOCS - 1, 19'h00001, 1'b0);
    send_triple(3, 19'h00000 | 19'h40000, 1'b0);
    for (int k = 0; k < 10; k++) send_triple($urandom % LOCS, 19'($urandom), 1'b0);
    send_word(12'h3FF);
    for (int k = 0; k < 3; k++) send_word(12'h000);
    repeat (2) @(negedge clk);
    chk(err_count == 5, "R6 counter steps per discarded word", 32'(err_count), 5);
    send_triple(7, 19'h12345, 1'b1);
    repeat (2) @(negedge clk);
    chk(fill_closed == 1'b1, "R7 closed after last record", 32'(fill_closed), 1);
    a = 8;
    while (exp_mem[fsel][a] != 0) a++;
    send_triple(a, 19'h55555, 1'b0);
    send_word(12'h001);
    repeat (2) @(negedge clk);
    chk(err_count == 6, "R6 counter continues", 32'(err_count), 6);
    verify_frame();
    tick();
    chk(fill_closed == 1'b0, "R7 tick reopens fill bank", 32'(fill_closed), 0);
    chk(readout_idle == 1'b0, "R8 tick restarts readout", 32'(readout_idle), 0);

    // frame 1: fill bank 1 with repeats, drain bank 0
    for (int k = 0; k < 15; k++) send_triple($urandom % 12, 19'($urandom), 1'b0);
    verify_frame();
    tick();
    // frame 2: no writes, drain bank 1
    verify_frame();
    tick();
    // frame 3: bank 0 again; the previous read cleared it
    verify_frame();
    chk(overrun == 1'b0, "R8 no overrun on full frames", 32'(overrun), 0);
    chk(err_count == 6, "R6 counter holds without bad words", 32'(err_count), 6);

    // short frame: tick before readout completes
    tick();
    repeat (20) @(negedge clk);
    chk(readout_idle == 1'b0, "R8 busy mid-frame", 32'(readout_idle), 0);
    tick();
    @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun on early tick", 32'(overrun), 1);
    repeat (30) @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun sticky", 32'(overrun), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule